// File: doc/BRIEF.md
# Receive Frame Status Classifier

This block sits beside a receive datapath and watches each incoming frame as a stream of bytes, with one strobe for the first byte and one for the last. It also watches a set of error strobes from the physical and MAC layers. When the frame ends it produces one 32-bit status word. The receive path writes that word into the completion field of the last descriptor of the frame.

The block counts the frame length, CRC included. It classifies the destination address from the leading six bytes, flags frames that are too long or too short, and keeps a sticky copy of every error strobe raised while the frame was in progress. The limit for long frames switches between a standard and an extended value, selected by an accept-long input. A filter-drop input forces the destination class to the rejected code.

The status word appears with a one-cycle valid pulse in the cycle after the last byte is taken. It then holds its value until the next frame ends.

Top module: `rx_status_classifier`

## Requirements
- R1: `status_valid` is high for exactly one cycle, namely the cycle after the clock edge that samples a byte with `frame_end` set. `status_word` keeps its value until the next such edge.
- R2: `status_word[11:0]` holds the number of bytes taken with `byte_valid` high, from the `frame_start` byte through the `frame_end` byte inclusive. Idle cycles are not counted. The count saturates at 4095 and does not wrap.
- R3: Bit 22 (too long) is set when the length is greater than 1518. When `accept_long` is high on the last byte, the limit is 2046 instead.
- R4: Bit 21 (runt) is set when the length is less than 64.
- R5: Bits 24:23 hold the destination class. The class is 00 when `filter_drop` is high on the last byte. Otherwise it is 11 when the first six bytes are all 0xFF. Otherwise it is 10 when bit 0 of the first byte is set, and 01 when it is not. A frame shorter than six bytes is never classed 11.
- R6: The following bits are set when the matching strobe is high in any cycle from the `frame_start` byte through the `frame_end` byte: bit 19 for `err_crc`, bit 18 for `err_align`, bit 17 for `loopback_flag`, bit 16 for `err_collision` and bit 25 for `err_overrun`. A strobe raised outside a frame has no effect. All flags restart with each frame.
- R7: Bit 20 (invalid symbol) is set only when `err_symbol` is high in a cycle inside the frame while `speed_100` is high in that same cycle.
- R8: Bit 26 (aborted) always equals bit 25. Bit 28 is always 1. Bits 31:29, bit 27 and bits 15:12 are 0.
- R9: After reset `status_valid` is 0 and `status_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A frame byte is present this cycle |
| byte_data | input | 8 | Frame byte |
| frame_start | input | 1 | This byte is the first of a frame |
| frame_end | input | 1 | This byte is the last of a frame |
| filter_drop | input | 1 | Address filter rejected the frame; sampled on the last byte |
| accept_long | input | 1 | Selects the extended length limit; sampled on the last byte |
| speed_100 | input | 1 | Link runs at 100 Mb/s; qualifies the symbol error |
| err_symbol | input | 1 | Invalid symbol strobe |
| err_crc | input | 1 | CRC mismatch strobe |
| err_align | input | 1 | Non-integral octet count strobe |
| err_collision | input | 1 | Collision seen during reception |
| err_overrun | input | 1 | Receive overrun strobe |
| loopback_flag | input | 1 | Frame came from a loopback transmission |
| status_valid | output | 1 | One-cycle pulse: status word is new |
| status_word | output | 32 | Receive status word |

## Verification
Lengths are driven on both sides of each boundary: 63 and 64, 1518 and 1519 with the standard limit, 2046 and 2047 with the extended limit, and a 4200-byte frame. These show whether each comparison is strict and whether the counter saturates or wraps. Address patterns include all-ones, group-bit, individual, a five-byte all-ones frame and a filter-dropped frame, which separates the class priority from the six-byte rule. Error strobes are placed on the first byte, the last byte, a middle byte and the idle gap between frames, which shows the boundaries of the capture window and that flags clear between frames. Random frames with idle gaps inside them check that idle cycles neither add to the length nor disturb address decoding.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;

  typedef enum logic [1:0] {
    DCLS_DROP  = 2'b00,
    DCLS_UCAST = 2'b01,
    DCLS_MCAST = 2'b10,
    DCLS_BCAST = 2'b11
  } dest_cls_e;

  typedef struct packed {
    logic sym;
    logic crc;
    logic align;
    logic loop;
    logic coll;
    logic ovr;
  } err_flags_t;

  localparam int B_FIXED   = 28;
  localparam int B_ABORT   = 26;
  localparam int B_OVERRUN = 25;
  localparam int B_CLS_LO  = 23;
  localparam int B_LONG    = 22;
  localparam int B_RUNT    = 21;
  localparam int B_SYM     = 20;
  localparam int B_CRC     = 19;
  localparam int B_ALIGN   = 18;
  localparam int B_LOOP    = 17;
  localparam int B_COLL    = 16;

endpackage

// File: rtl/rx_len_counter.sv
module rx_len_counter #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_en,
  input  logic             first,
  output logic [LEN_W-1:0] len_q,
  output logic [LEN_W-1:0] len_nxt
);

  localparam logic [LEN_W-1:0] LEN_MAX = '1;
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  always_comb begin
    len_nxt = len_q;
    if (byte_en) begin
      if (first)
        len_nxt = LEN_ONE;
      else if (len_q == LEN_MAX)
        len_nxt = LEN_MAX;
      else
        len_nxt = len_q + LEN_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      len_q <= '0;
    else if (byte_en)
      len_q <= len_nxt;
  end

endmodule

// File: rtl/rx_dest_classify.sv
module rx_dest_classify #(
  parameter int LEN_W      = 12,
  parameter int ADDR_BYTES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_en,
  input  logic             first,
  input  logic [7:0]       data,
  input  logic [LEN_W-1:0] len_q,
  output logic             bcast_nxt,
  output logic             mcast_nxt
);

  localparam logic [LEN_W-1:0] ADDR_END = LEN_W'(ADDR_BYTES);

  logic             all_ones_q;
  logic             group_q;
  logic             in_addr;
  logic             is_ff;

  assign is_ff   = (data == 8'hFF);
  assign in_addr = (len_q < ADDR_END);

  always_comb begin
    bcast_nxt = all_ones_q;
    mcast_nxt = group_q;
    if (byte_en) begin
      if (first) begin
        bcast_nxt = is_ff;
        mcast_nxt = data[0];
      end else if (in_addr) begin
        bcast_nxt = all_ones_q & is_ff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      all_ones_q <= 1'b0;
      group_q    <= 1'b0;
    end else if (byte_en) begin
      all_ones_q <= bcast_nxt;
      group_q    <= mcast_nxt;
    end
  end

endmodule

// File: rtl/rx_err_latch.sv
module rx_err_latch
  import rx_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       active,
  input  err_flags_t strobe,
  output err_flags_t flags_nxt
);

  err_flags_t flags_q;
  err_flags_t base;

  always_comb begin
    base      = clr ? '0 : flags_q;
    flags_nxt = base | (active ? strobe : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags_q <= '0;
    else if (active)
      flags_q <= flags_nxt;
  end

endmodule

// File: rtl/rx_status_classifier.sv
module rx_status_classifier
  import rx_stat_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int ADDR_BYTES = 6,
  parameter int MIN_LEN    = 64,
  parameter int STD_MAX    = 1518,
  parameter int EXT_MAX    = 2046
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  input  logic        frame_start,
  input  logic        frame_end,
  input  logic        filter_drop,
  input  logic        accept_long,
  input  logic        speed_100,
  input  logic        err_symbol,
  input  logic        err_crc,
  input  logic        err_align,
  input  logic        err_collision,
  input  logic        err_overrun,
  input  logic        loopback_flag,
  output logic        status_valid,
  output logic [31:0] status_word
);

  localparam logic [LEN_W-1:0] MIN_LIM  = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] STD_LIM  = LEN_W'(STD_MAX);
  localparam logic [LEN_W-1:0] EXT_LIM  = LEN_W'(EXT_MAX);
  localparam logic [LEN_W-1:0] ADDR_LIM = LEN_W'(ADDR_BYTES);

  logic             sof_byte;
  logic             eof_byte;
  logic             in_frame_q;
  logic             in_frame_nxt;
  logic             active;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] len_nxt;
  logic             bcast_nxt;
  logic             mcast_nxt;
  err_flags_t       strobe;
  err_flags_t       flags_nxt;
  dest_cls_e        cls;
  logic [31:0]      word_nxt;

  assign sof_byte = byte_valid & frame_start;
  assign eof_byte = byte_valid & frame_end;
  assign active   = in_frame_q | sof_byte;

  always_comb begin
    strobe.sym   = err_symbol & speed_100;
    strobe.crc   = err_crc;
    strobe.align = err_align;
    strobe.loop  = loopback_flag;
    strobe.coll  = err_collision;
    strobe.ovr   = err_overrun;
  end

  rx_len_counter #(.LEN_W(LEN_W)) u_len (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_en (byte_valid),
    .first   (frame_start),
    .len_q   (len_q),
    .len_nxt (len_nxt)
  );

  rx_dest_classify #(.LEN_W(LEN_W), .ADDR_BYTES(ADDR_BYTES)) u_dest (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_en   (byte_valid),
    .first     (frame_start),
    .data      (byte_data),
    .len_q     (len_q),
    .bcast_nxt (bcast_nxt),
    .mcast_nxt (mcast_nxt)
  );

  rx_err_latch u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sof_byte),
    .active    (active),
    .strobe    (strobe),
    .flags_nxt (flags_nxt)
  );

  always_comb begin
    in_frame_nxt = in_frame_q;
    if (eof_byte)
      in_frame_nxt = 1'b0;
    else if (sof_byte)
      in_frame_nxt = 1'b1;
  end

  always_comb begin
    if (filter_drop)
      cls = DCLS_DROP;
    else if (bcast_nxt && (len_nxt >= ADDR_LIM))
      cls = DCLS_BCAST;
    else if (mcast_nxt)
      cls = DCLS_MCAST;
    else
      cls = DCLS_UCAST;
  end

  always_comb begin
    word_nxt                        = '0;
    word_nxt[LEN_W-1:0]             = len_nxt;
    word_nxt[B_FIXED]               = 1'b1;
    word_nxt[B_ABORT]               = flags_nxt.ovr;
    word_nxt[B_OVERRUN]             = flags_nxt.ovr;
    word_nxt[B_CLS_LO+1:B_CLS_LO]   = cls;
    word_nxt[B_LONG]                = len_nxt > (accept_long ? EXT_LIM : STD_LIM);
    word_nxt[B_RUNT]                = len_nxt < MIN_LIM;
    word_nxt[B_SYM]                 = flags_nxt.sym;
    word_nxt[B_CRC]                 = flags_nxt.crc;
    word_nxt[B_ALIGN]               = flags_nxt.align;
    word_nxt[B_LOOP]                = flags_nxt.loop;
    word_nxt[B_COLL]                = flags_nxt.coll;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q   <= 1'b0;
      status_valid <= 1'b0;
      status_word  <= '0;
    end else begin
      in_frame_q   <= in_frame_nxt;
      status_valid <= eof_byte;
      if (eof_byte)
        status_word <= word_nxt;
    end
  end

endmodule

// File: rtl/rx_status_checker.sv
module rx_status_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_valid,
  input logic        frame_end,
  input logic        status_valid,
  input logic [31:0] status_word
);

  // R1: a last byte is followed by a status pulse
  a_r1_pulse_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && frame_end) |=> status_valid);

  // R1: no pulse without a last byte one cycle earlier
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> $past(byte_valid && frame_end));

  // R1: word holds between frame ends
  a_r1_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && frame_end) |=> $stable(status_word));

  // R8: aborted mirrors overrun
  a_r8_abort_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> (status_word[26] == status_word[25]));

  // R8: fixed and zero bits
  a_r8_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> (status_word[28] && status_word[31:29] == 3'b000 &&
                      !status_word[27] && status_word[15:12] == 4'h0));

  // R4: runt and too-long never coexist
  a_r4_long_runt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> !(status_word[22] && status_word[21]));

  // R5: broadcast class only with a full address
  a_r5_bcast_full_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (status_valid && status_word[24:23] == 2'b11) |-> (status_word[11:0] >= 12'd6));

endmodule

bind rx_status_classifier rx_status_checker i_rx_status_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .byte_valid   (byte_valid),
  .frame_end    (frame_end),
  .status_valid (status_valid),
  .status_word  (status_word)
);

// File: tb/test_rx_status_classifier.sv
module test_rx_status_classifier;

  logic        clk;
  logic        rst_n;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic        frame_start;
  logic        frame_end;
  logic        filter_drop;
  logic        accept_long;
  logic        speed_100;
  logic        err_symbol;
  logic        err_crc;
  logic        err_align;
  logic        err_collision;
  logic        err_overrun;
  logic        loopback_flag;
  logic        status_valid;
  logic [31:0] status_word;

  int checks;
  int errors;
  bit done;
  int inj [0:5];   // 0 crc, 1 align, 2 loop, 3 coll, 4 overrun, 5 symbol

  rx_status_classifier i_rx_status_classifier (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .frame_start(frame_start), .frame_end(frame_end), .filter_drop(filter_drop),
    .accept_long(accept_long), .speed_100(speed_100), .err_symbol(err_symbol),
    .err_crc(err_crc), .err_align(err_align), .err_collision(err_collision),
    .err_overrun(err_overrun), .loopback_flag(loopback_flag),
    .status_valid(status_valid), .status_word(status_word)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] exp_word(input int len, input logic [47:0] da,
                                           input bit drop, input bit along,
                                           input bit spd, input bit [5:0] hit);
    logic [31:0] w;
    int lc;
    lc = (len > 4095) ? 4095 : len;
    w = '0;
    w[28] = 1'b1;
    w[11:0] = 12'(lc);
    w[22] = lc > (along ? 2046 : 1518);
    w[21] = lc < 64;
    if (drop) w[24:23] = 2'b00;
    else if (len >= 6 && da == 48'hFFFF_FFFF_FFFF) w[24:23] = 2'b11;
    else if (da[40]) w[24:23] = 2'b10;
    else w[24:23] = 2'b01;
    w[19] = hit[0];
    w[18] = hit[1];
    w[17] = hit[2];
    w[16] = hit[3];
    w[25] = hit[4];
    w[26] = hit[4];
    w[20] = hit[5] & spd;
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    byte_valid = 0; frame_start = 0; frame_end = 0; byte_data = 8'h00;
    err_symbol = 0; err_crc = 0; err_align = 0; err_collision = 0;
    err_overrun = 0; loopback_flag = 0;
  endtask

  task automatic clear_inj();
    for (int k = 0; k < 6; k++) inj[k] = -1;
  endtask

  task automatic run_frame(input int len, input logic [47:0] da, input bit drop,
                           input bit along, input bit spd, input bit gaps,
                           input string tag);
    bit [5:0] hit;
    logic [31:0] e;
    for (int k = 0; k < 6; k++) hit[k] = (inj[k] >= 0) && (inj[k] < len);
    e = exp_word(len, da, drop, along, spd, hit);
    for (int i = 0; i < len; i++) begin
      if (gaps && i > 0 && ($urandom % 6) == 0) begin
        @(negedge clk);
        idle_inputs();
      end
      @(negedge clk);
      byte_valid    = 1;
      frame_start   = (i == 0);
      frame_end     = (i == len - 1);
      byte_data     = (i < 6) ? da[47 - 8*i -: 8] : 8'($urandom);
      filter_drop   = drop;
      accept_long   = along;
      speed_100     = spd;
      err_crc       = (inj[0] == i);
      err_align     = (inj[1] == i);
      loopback_flag = (inj[2] == i);
      err_collision = (inj[3] == i);
      err_overrun   = (inj[4] == i);
      err_symbol    = (inj[5] == i);
    end
    @(negedge clk);
    idle_inputs();
    check(status_valid === 1'b1 && status_word === e, {tag, " R1 word at pulse"},
          status_word, e);
    @(negedge clk);
    check(status_valid === 1'b0 && status_word === e, "R1 pulse ends, word holds",
          {31'b0, status_valid} | (status_word ^ e), 32'h0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    void'($urandom(32'd2718));
    clear_inj();
    idle_inputs();
    filter_drop = 0; accept_long = 0; speed_100 = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(status_valid === 1'b0 && status_word === 32'h0, "R9 reset state",
          status_word, 32'h0);
    rst_n = 1;
    @(negedge clk);

    run_frame(1518, 48'h0012_3456_789A, 0, 0, 1, 0, "R3 1518 std not long");
    run_frame(1519, 48'h0012_3456_789A, 0, 0, 1, 0, "R3 1519 std long");
    run_frame(1519, 48'h0012_3456_789A, 0, 1, 1, 0, "R3 1519 ext not long");
    run_frame(2046, 48'h0012_3456_789A, 0, 1, 1, 0, "R3 2046 ext not long");
    run_frame(2047, 48'h0012_3456_789A, 0, 1, 1, 0, "R3 2047 ext long");
    run_frame(63, 48'h0012_3456_789A, 0, 0, 1, 0, "R4 63 runt");
    run_frame(64, 48'h0012_3456_789A, 0, 0, 1, 0, "R4 64 not runt");
    run_frame(4200, 48'h0012_3456_789A, 0, 0, 1, 0, "R2 saturation");
    run_frame(1, 48'hFF00_0000_0000, 0, 0, 1, 0, "R2 one byte frame");
    run_frame(64, 48'hFFFF_FFFF_FFFF, 0, 0, 1, 0, "R5 broadcast");
    run_frame(5, 48'hFFFF_FFFF_FFFF, 0, 0, 1, 0, "R5 short all-ones");
    run_frame(64, 48'hFFFF_FFFF_FFFE, 0, 0, 1, 0, "R5 near-broadcast");
    run_frame(64, 48'h0100_5E00_0001, 0, 0, 1, 0, "R5 multicast");
    run_frame(64, 48'hFFFF_FFFF_FFFF, 1, 0, 1, 0, "R5 dropped");

    // R6: strobes outside a frame are ignored, flags start clean
    inj[0] = 10; inj[3] = 0; inj[4] = 69;
    run_frame(70, 48'h0012_3456_789A, 0, 0, 1, 0, "R6 first/mid/last strobes");
    clear_inj();
    @(negedge clk);
    err_crc = 1; err_collision = 1; err_overrun = 1; loopback_flag = 1; err_align = 1;
    repeat (3) @(negedge clk);
    idle_inputs();
    run_frame(70, 48'h0012_3456_789A, 0, 0, 1, 0, "R6 gap strobes ignored");

    inj[5] = 20;
    run_frame(80, 48'h0012_3456_789A, 0, 0, 0, 0, "R7 symbol at low speed");
    run_frame(80, 48'h0012_3456_789A, 0, 0, 1, 0, "R7 symbol at 100");
    clear_inj();
    inj[4] = 30;
    run_frame(80, 48'h0012_3456_789A, 0, 0, 1, 0, "R8 overrun mirror");
    clear_inj();

    for (int n = 0; n < 30; n++) begin
      int len;
      logic [47:0] da;
      int sel;
      sel = $urandom % 4;
      case (sel)
        0: len = 1 + ($urandom % 80);
        1: len = 1500 + ($urandom % 30);
        2: len = 2035 + ($urandom % 20);
        default: len = 60 + ($urandom % 200);
      endcase
      da = {$urandom, 16'($urandom)};
      if (($urandom % 4) == 0) da = 48'hFFFF_FFFF_FFFF;
      for (int k = 0; k < 6; k++)
        inj[k] = (($urandom % 3) == 0) ? int'($urandom % (len + 4)) : -1;
      run_frame(len, da, ($urandom % 8) == 0, $urandom % 2, $urandom % 2, 1,
                "R2 R5 R6 random");
    end
    clear_inj();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule